// File: doc/BRIEF.md
# Accumulator and Link-Bit Unit

This block holds a 16-bit working accumulator together with a single link flip-flop that acts as a seventeenth bit. Its bit-sliced adder-and-logic network combines the accumulator with a 16-bit memory operand or an 8-bit input byte. The same network rotates the accumulator through the link and produces the next value for the register. The instruction sequencer drives it with decoded selects and qualifiers. The block returns the accumulator to the common bus and reports four status bits that the conditional-skip logic tests.

Each operation takes one clock edge. Three memory-operand operations (AND, add, load) are qualified by an execute-phase strobe. Register-reference operations are selected by single bits of the instruction's operation field when the register-reference qualifier is high. The byte input is taken when the input/output qualifier is high and the top bit of that field is set. Clear and increment act on the register's own clear and count controls. Every other change loads the output of the network.

Top module: `acc_link_unit`

## Requirements
- R1: While `rst_n` is low the accumulator and the link are both 0. After reset, `acc_bus` reads 0000h, `acc_zero` is 1 and `link_zero` is 1.
- R2: The AND, add and load-operand operations happen only on an edge where `slot_t5` is 1. They are selected by `opc_sel[0]`, `opc_sel[1]` and `opc_sel[2]` respectively. With `slot_t5` at 0 these selects change nothing.
- R3: Add writes the low 16 bits of AC+`dr_in` into the accumulator and bit 16 of that sum (the carry) into the link.
- R4: AND writes AC & `dr_in`, and load-operand writes `dr_in`. Both leave the link unchanged.
- R5: When `io_ref` is 1 and `op_field[11]` is 1, `in_byte` is written into AC[7:0]. AC[15:8] and the link keep their values.
- R6: With `reg_ref` at 1, `op_field[11]` clears the accumulator and `op_field[10]` clears the link.
- R7: With `reg_ref` at 1, `op_field[9]` inverts every accumulator bit and `op_field[8]` inverts the link.
- R8: With `reg_ref` at 1, `op_field[7]` rotates right through the link: the new link is the old AC[0], the new AC[15] is the old link, and the new AC[i] is the old AC[i+1].
- R9: With `reg_ref` at 1, `op_field[6]` rotates left through the link: the new link is the old AC[15], the new AC[0] is the old link, and the new AC[i] is the old AC[i-1].
- R10: With `reg_ref` at 1, `op_field[5]` adds 1 to the accumulator. FFFFh wraps to 0000h, and the link is unchanged.
- R11: `acc_bus` always equals the accumulator. `sign_pos` is the inverse of AC[15] and `sign_neg` equals AC[15]. `acc_zero` is 1 exactly when AC is 0000h, and `link_zero` is 1 exactly when the link is 0.
- R12: The unit acts only when exactly one request is active on an edge. A request is one of the eleven qualified terms of R2, R5, R6, R7, R8, R9 and R10. If none or more than one is active, the accumulator and the link both hold. Examples are `io_ref` with only `op_field[9]` set, or two register-reference bits set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_t5 | input | 1 | Execute-phase strobe for the memory-operand operations |
| opc_sel | input | 3 | Decoded memory-operand select: bit0 AND, bit1 add, bit2 load |
| reg_ref | input | 1 | Register-reference qualifier |
| io_ref | input | 1 | Input/output qualifier |
| op_field | input | 7 | Instruction bits 11 down to 5 |
| dr_in | input | 16 | Memory operand |
| in_byte | input | 8 | Input character byte |
| acc_bus | output | 16 | Accumulator value to the bus |
| sign_pos | output | 1 | AC[15] is 0 |
| sign_neg | output | 1 | AC[15] is 1 |
| acc_zero | output | 1 | Accumulator is zero |
| link_zero | output | 1 | Link is zero |

## Verification
The bench targets the edges of the carry and rotate paths:
- FFFFh+0001h must leave zero with the link set. A design that drops the carry leaves the link at 0.
- 8000h+8000h must also leave zero with the link set.
- Rotating 8000h left and back checks that the link really is the seventeenth bit. A plain shift instead of a rotate returns 0000h.
- Incrementing FFFFh while the link is set must wrap to zero and leave the link alone. A design that routes the increment through the adder would clear or set the link.

The byte load must preserve the upper byte, which a full-width load would lose. Requests that collide, and requests left ungated by `slot_t5`, must leave the state untouched rather than obey one of them.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;

    localparam int ACC_W  = 16;
    localparam int BYTE_W = 8;
    localparam int FLD_LO = 5;
    localparam int FLD_HI = 11;
    localparam int NREQ   = 11;

    typedef enum logic [3:0] {
        OP_HOLD,
        OP_AND,
        OP_ADD,
        OP_LDR,
        OP_INB,
        OP_CLA,
        OP_CLE,
        OP_CMA,
        OP_CME,
        OP_SHR,
        OP_SHL,
        OP_INC
    } acc_op_t;

    typedef struct packed {
        logic [ACC_W-1:0] ac;
        logic             e;
    } acc_state_t;

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
    import acc_link_pkg::*;
(
    input  logic               slot_t5,
    input  logic [2:0]         opc_sel,
    input  logic               reg_ref,
    input  logic               io_ref,
    input  logic [FLD_HI:FLD_LO] op_field,
    output acc_op_t            op,
    output logic               clash
);
    logic [NREQ-1:0] req;
    int unsigned     cnt;

    always_comb begin
        req[0]  = slot_t5 & opc_sel[0];
        req[1]  = slot_t5 & opc_sel[1];
        req[2]  = slot_t5 & opc_sel[2];
        req[3]  = io_ref  & op_field[11];
        req[4]  = reg_ref & op_field[11];
        req[5]  = reg_ref & op_field[10];
        req[6]  = reg_ref & op_field[9];
        req[7]  = reg_ref & op_field[8];
        req[8]  = reg_ref & op_field[7];
        req[9]  = reg_ref & op_field[6];
        req[10] = reg_ref & op_field[5];
    end

    always_comb begin
        cnt   = $countones(req);
        clash = (cnt > 1);
        op    = OP_HOLD;
        if (cnt == 1) begin
            unique case (1'b1)
                req[0]:  op = OP_AND;
                req[1]:  op = OP_ADD;
                req[2]:  op = OP_LDR;
                req[3]:  op = OP_INB;
                req[4]:  op = OP_CLA;
                req[5]:  op = OP_CLE;
                req[6]:  op = OP_CMA;
                req[7]:  op = OP_CME;
                req[8]:  op = OP_SHR;
                req[9]:  op = OP_SHL;
                default: op = OP_INC;
            endcase
        end
    end

endmodule

// File: rtl/acc_bit_cell.sv
module acc_bit_cell
    import acc_link_pkg::*;
(
    input  acc_op_t op,
    input  logic    a,
    input  logic    d,
    input  logic    s,
    input  logic    lft,
    input  logic    rgt,
    input  logic    cin,
    output logic    y,
    output logic    cout
);
    always_comb begin
        cout = 1'b0;
        unique case (op)
            OP_AND: y = a & d;
            OP_ADD: begin
                y    = a ^ d ^ cin;
                cout = (a & d) | (cin & (a ^ d));
            end
            OP_LDR, OP_INB: y = s;
            OP_CMA: y = ~a;
            OP_SHR: y = lft;
            OP_SHL: y = rgt;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/acc_logic_net.sv
module acc_logic_net
    import acc_link_pkg::*;
#(
    parameter int W  = ACC_W,
    parameter int BW = BYTE_W
) (
    input  acc_op_t        op,
    input  logic [W-1:0]   ac_q,
    input  logic           e_q,
    input  logic [W-1:0]   dr_in,
    input  logic [BW-1:0]  in_byte,
    output logic [W-1:0]   res,
    output logic           e_res
);
    logic [W:0]   carry;
    logic [W-1:0] src;

    assign carry[0] = 1'b0;

    always_comb begin
        if (op == OP_INB) src = {ac_q[W-1:BW], in_byte};
        else              src = dr_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic lft_b, rgt_b;
        if (i == W-1) begin : g_top
            assign lft_b = e_q;
        end else begin : g_mid_l
            assign lft_b = ac_q[i+1];
        end
        if (i == 0) begin : g_bot
            assign rgt_b = e_q;
        end else begin : g_mid_r
            assign rgt_b = ac_q[i-1];
        end
        acc_bit_cell u_cell (
            .op   (op),
            .a    (ac_q[i]),
            .d    (dr_in[i]),
            .s    (src[i]),
            .lft  (lft_b),
            .rgt  (rgt_b),
            .cin  (carry[i]),
            .y    (res[i]),
            .cout (carry[i+1])
        );
    end

    always_comb begin
        unique case (op)
            OP_ADD:  e_res = carry[W];
            OP_SHR:  e_res = ac_q[0];
            OP_SHL:  e_res = ac_q[W-1];
            OP_CLE:  e_res = 1'b0;
            OP_CME:  e_res = ~e_q;
            default: e_res = e_q;
        endcase
    end

endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
    import acc_link_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_t5,
    input  logic [2:0]           opc_sel,
    input  logic                 reg_ref,
    input  logic                 io_ref,
    input  logic [FLD_HI:FLD_LO] op_field,
    input  logic [ACC_W-1:0]     dr_in,
    input  logic [BYTE_W-1:0]    in_byte,
    output logic [ACC_W-1:0]     acc_bus,
    output logic                 sign_pos,
    output logic                 sign_neg,
    output logic                 acc_zero,
    output logic                 link_zero
);
    acc_op_t          op;
    logic             clash;
    logic [ACC_W-1:0] net_res;
    logic             net_e;
    acc_state_t       st_d, st_q;
    logic             ac_ld, ac_inr, ac_clr;

    acc_op_decode u_dec (
        .slot_t5  (slot_t5),
        .opc_sel  (opc_sel),
        .reg_ref  (reg_ref),
        .io_ref   (io_ref),
        .op_field (op_field),
        .op       (op),
        .clash    (clash)
    );

    acc_logic_net #(.W(ACC_W), .BW(BYTE_W)) u_net (
        .op      (op),
        .ac_q    (st_q.ac),
        .e_q     (st_q.e),
        .dr_in   (dr_in),
        .in_byte (in_byte),
        .res     (net_res),
        .e_res   (net_e)
    );

    // register controls: clear and count are separate from parallel load
    always_comb begin
        ac_clr = (op == OP_CLA);
        ac_inr = (op == OP_INC);
        ac_ld  = (op == OP_AND) || (op == OP_ADD) || (op == OP_LDR) ||
                 (op == OP_INB) || (op == OP_CMA) || (op == OP_SHR) ||
                 (op == OP_SHL);
    end

    always_comb begin
        st_d = st_q;
        if (ac_clr)      st_d.ac = '0;
        else if (ac_inr) st_d.ac = st_q.ac + 1'b1;
        else if (ac_ld)  st_d.ac = net_res;
        st_d.e = net_e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_bus   = st_q.ac;
    assign sign_neg  = st_q.ac[ACC_W-1];
    assign sign_pos  = ~st_q.ac[ACC_W-1];
    assign acc_zero  = (st_q.ac == '0);
    assign link_zero = ~st_q.e;

    p_t5_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_t5 && !reg_ref && !io_ref) |=> $stable(st_q));

    p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |=>
        ({st_q.e, st_q.ac} == ({1'b0, $past(st_q.ac)} + {1'b0, $past(dr_in)})));

    p_byte_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INB) |=>
        (st_q.ac[ACC_W-1:BYTE_W] == $past(st_q.ac[ACC_W-1:BYTE_W]) &&
         st_q.ac[BYTE_W-1:0] == $past(in_byte) && st_q.e == $past(st_q.e)));

    p_rot_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHR) |=>
        (st_q.e == $past(st_q.ac[0]) && st_q.ac[ACC_W-1] == $past(st_q.e)));

    p_rot_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHL) |=>
        (st_q.e == $past(st_q.ac[ACC_W-1]) && st_q.ac[0] == $past(st_q.e)));

    p_inc_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC) |=> $stable(st_q.e));

    p_clash_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> $stable(st_q));

endmodule

// File: tb/acc_link_unit_tb.sv
module acc_link_unit_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_t5 = 1'b0;
    logic [2:0]  opc_sel = '0;
    logic        reg_ref = 1'b0;
    logic        io_ref = 1'b0;
    logic [11:5] op_field = '0;
    logic [15:0] dr_in = '0;
    logic [7:0]  in_byte = '0;
    logic [15:0] acc_bus;
    logic        sign_pos, sign_neg, acc_zero, link_zero;

    int vectors = 0;
    int errs = 0;
    logic [15:0] m_ac = '0;
    logic        m_e = 1'b0;
    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    acc_link_unit u_dut (
        .clk(clk), .rst_n(rst_n), .slot_t5(slot_t5), .opc_sel(opc_sel),
        .reg_ref(reg_ref), .io_ref(io_ref), .op_field(op_field),
        .dr_in(dr_in), .in_byte(in_byte), .acc_bus(acc_bus),
        .sign_pos(sign_pos), .sign_neg(sign_neg), .acc_zero(acc_zero),
        .link_zero(link_zero)
    );

    task automatic compare(input logic [16:0] ex, input string tag);
        logic [16:0] act;
        logic [3:0]  fl_a, fl_e;
        act  = {~link_zero, acc_bus};
        fl_a = {sign_pos, sign_neg, acc_zero, link_zero};
        fl_e = {~ex[15], ex[15], (ex[15:0] == 16'h0), ~ex[16]};
        vectors++;
        if (act !== ex || fl_a !== fl_e) begin
            errs++;
            $display("FAIL %s: {E,AC}=%05h flags=%b expected {E,AC}=%05h flags=%b",
                     tag, act, fl_a, ex, fl_e);
        end
    endtask

    // reference model built from the requirement list
    task automatic model(input logic t5, input logic [2:0] os, input logic rr,
                         input logic io, input logic [11:5] f,
                         input logic [15:0] d, input logic [7:0] b);
        logic [10:0] rq;
        logic [16:0] sum;
        rq = {rr & f[5], rr & f[6], rr & f[7], rr & f[8], rr & f[9], rr & f[10],
              rr & f[11], io & f[11], t5 & os[2], t5 & os[1], t5 & os[0]};
        if ($countones(rq) == 1) begin
            if (rq[0]) m_ac = m_ac & d;
            if (rq[1]) begin sum = {1'b0, m_ac} + {1'b0, d}; m_ac = sum[15:0]; m_e = sum[16]; end
            if (rq[2]) m_ac = d;
            if (rq[3]) m_ac = {m_ac[15:8], b};
            if (rq[4]) m_ac = 16'h0;
            if (rq[5]) m_e = 1'b0;
            if (rq[6]) m_ac = ~m_ac;
            if (rq[7]) m_e = ~m_e;
            if (rq[8]) begin sum = {m_ac[0], m_e, m_ac[15:1]}; m_e = sum[16]; m_ac = sum[15:0]; end
            if (rq[9]) begin sum = {m_ac[15], m_ac[14:0], m_e}; m_e = sum[16]; m_ac = sum[15:0]; end
            if (rq[10]) m_ac = m_ac + 16'h1;
        end
    endtask

    task automatic drive(input logic t5, input logic [2:0] os, input logic rr,
                         input logic io, input logic [11:5] f,
                         input logic [15:0] d, input logic [7:0] b, input string tag);
        @(negedge clk);
        slot_t5 = t5; opc_sel = os; reg_ref = rr; io_ref = io;
        op_field = f; dr_in = d; in_byte = b;
        model(t5, os, rr, io, f, d, b);
        exp_q.push_back({m_e, m_ac});
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    task automatic ldr(input logic [15:0] d, input string tag);
        drive(1'b1, 3'b100, 1'b0, 1'b0, 7'h00, d, 8'h00, tag);
    endtask

    task automatic rref(input logic [11:5] f, input string tag);
        drive(1'b0, 3'b000, 1'b1, 1'b0, f, 16'h0, 8'h00, tag);
    endtask

    // monitor: pops one expected item per applied vector
    always @(posedge clk) begin
        #(CLK_P/4);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    initial begin
        #(CLK_P * 200000);
        errs++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(17'h0, "R1 reset state");
        rst_n = 1'b1;

        ldr(16'h8000, "R4 load operand 8000");
        rref(7'b0000010, "R9 rotate left 8000 -> link");
        rref(7'b0000100, "R8 rotate right back to 8000");
        ldr(16'hFFFF, "R4 load FFFF");
        drive(1'b1, 3'b010, 1'b0, 1'b0, 7'h00, 16'h0001, 8'h00, "R3 add FFFF+1 carry");
        rref(7'b0000001, "R10 increment keeps link");
        ldr(16'hFFFF, "R4 load FFFF again");
        rref(7'b0000001, "R10 increment wraps FFFF");
        rref(7'b0001000, "R7 complement link");
        rref(7'b0010000, "R7 complement AC");
        rref(7'b1000000, "R6 clear AC");
        rref(7'b0001000, "R7 set link");
        rref(7'b0100000, "R6 clear link");
        ldr(16'h8000, "R4 load 8000");
        drive(1'b1, 3'b010, 1'b0, 1'b0, 7'h00, 16'h8000, 8'h00, "R3 add 8000+8000");
        ldr(16'h7FFF, "R4 load 7FFF");
        drive(1'b1, 3'b010, 1'b0, 1'b0, 7'h00, 16'h0001, 8'h00, "R3 add 7FFF+1 sign R11");
        ldr(16'h0F0F, "R4 load 0F0F");
        drive(1'b1, 3'b001, 1'b0, 1'b0, 7'h00, 16'hF0FF, 8'h00, "R4 AND with F0FF");
        drive(1'b0, 3'b010, 1'b0, 1'b0, 7'h00, 16'h1234, 8'h00, "R2 add without t5 ignored");
        drive(1'b0, 3'b100, 1'b0, 1'b0, 7'h00, 16'hBEEF, 8'h00, "R2 load without t5 ignored");
        ldr(16'hABCD, "R4 load ABCD");
        drive(1'b0, 3'b000, 1'b0, 1'b1, 7'b1000000, 16'h0, 8'h5A, "R5 byte load keeps upper");
        drive(1'b0, 3'b000, 1'b0, 1'b1, 7'b0010000, 16'h0, 8'hFF, "R12 io without bit11 holds");
        rref(7'b1010000, "R12 two register bits hold");
        drive(1'b1, 3'b011, 1'b0, 1'b0, 7'h00, 16'h0001, 8'h00, "R12 two operand selects hold");
        drive(1'b1, 3'b001, 1'b1, 1'b0, 7'b0000001, 16'h0000, 8'h00, "R12 operand and register clash holds");
        rref(7'b0000000, "R12 no request holds R11");

        for (int k = 0; k < 300; k++) begin
            int sel;
            logic [15:0] d;
            sel = int'($urandom_range(0, 10));
            d   = 16'($urandom);
            if (sel < 3)       drive(1'b1, 3'(1 << sel), 1'b0, 1'b0, 7'h00, d, 8'h00, "R2 R3 R4 random operand op");
            else if (sel == 3) drive(1'b0, 3'b000, 1'b0, 1'b1, 7'b1000000, d, d[15:8], "R5 random byte load");
            else               rref(7'(1 << (sel - 4)), "R6 R7 R8 R9 R10 random register op");
        end

        repeat (2) @(posedge clk);
        #(CLK_P/2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule